// File: doc/BRIEF.md
# Spread-Spectrum Track Waveform Generator

The block turns a stream of bit-type codes into the two-phase drive for a model railway command track. Each accepted code selects one bit symbol. Output A is high in the first half of the symbol and output B in the second half, and a short guard interval keeps both outputs low around every polarity change. A free-running tick counter times each symbol against a table that holds the period and transition point for every bit type.

When the jitter input is high, the block stretches each symbol by a pseudorandom spread S. S is added to the transition point and 2·S to the period, so the two halves of a DCC bit stay exactly equal while the repetition frequency wanders. This spreads the emitted energy over a wider band. A linear congruential generator supplies S. A new value is drawn only when the bit type changes, or when four further bits of the same type have reused the current timing.

The producer offers codes through a valid/ready handshake. A code is taken only on the last tick of a symbol. When no code is offered at that point, the block sends a DCC one bit.

Top module: `dcc_jitter_gen`

## Requirements
- R1: During reset and on the first cycle after it, out_a and out_b are low, in_ready is high, and the generator seed holds 0xB7A11BAE.
- R2: Codes are 0 = DCC zero and 1 = DCC one. With no spread, a DCC zero lasts 200·CLK_PER_US ticks with its transition at 100·CLK_PER_US, and a DCC one lasts 112·CLK_PER_US ticks with its transition at 56·CLK_PER_US.
- R3: out_a and out_b are never high together. Both are low for DEADBAND ticks at the start of each symbol and for DEADBAND ticks after its transition point, so each symbol has exactly 2·DEADBAND ticks with both outputs low.
- R4: in_ready is high only before the first symbol and on the last tick of each symbol. A code is taken whenever in_ready is high, the new symbol starts on the next tick, and an absent code (in_valid low) sends a DCC one.
- R5: For DCC bits the period equals twice the transition point. out_a is then high for transition−DEADBAND ticks, and out_b is high for the same number of ticks.
- R6: A drawn spread lies in [CLK_PER_US/2, max−1] ticks, where max is 5·CLK_PER_US for a DCC zero, 4·CLK_PER_US for a DCC one and 2·CLK_PER_US for the alternate-protocol bits.
- R7: Each draw first sets seed = ((seed·52253 + 42767) mod 2^32) mod 65213. The spread is then seed mod (max − min) + min, and the symbol uses transition + S and period + 2·S.
- R8: Timing is reloaded when the code differs from the previous symbol's code, or when the four symbols after a reload have reused that timing. A symbol that is not reloaded uses exactly the spread of the symbol before it.
- R9: If jitter_en is low at a reload, the spread is 0, the nominal timing is used, and the seed does not advance.
- R10: Codes 2 and 3 are alternate-protocol zero and one bits. Both last 208·CLK_PER_US + 2·S ticks, with the transition at 26·CLK_PER_US + S for code 2 and at 182·CLK_PER_US + S for code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jitter_en | input | 1 | Enables the pseudorandom stretch, sampled at each reload |
| in_valid | input | 1 | A bit code is offered |
| in_code | input | 2 | Bit type: 0 DCC zero, 1 DCC one, 2 alternate zero, 3 alternate one |
| in_ready | output | 1 | The block takes a code (or an implied one bit) at this edge |
| out_a | output | 1 | Bridge drive, first half of each symbol |
| out_b | output | 1 | Bridge drive, second half of each symbol |

## Verification
The assertions check the cycle-level properties on every cycle: the two outputs never overlap and a guard gap follows every falling edge, the counter restarts at a handshake, the repeat counter stays bounded, the seed stays below the modulus and holds still when no draw occurs, the DCC period stays symmetric and the spread is zero after a reload with jitter off. Only the bench scenarios can show that measured high times, symbol lengths and guard gaps match each bit type, that the spread sequence follows the generator step by step, that the spread is reused for exactly four bits and then redrawn, and that an idle producer yields one bits.

// File: rtl/dcc_jit_pkg.sv
package dcc_jit_pkg;

    typedef logic [31:0] tick_t;

    typedef enum logic [1:0] {
        KIND_ZERO = 2'd0,
        KIND_ONE  = 2'd1,
        KIND_ALT0 = 2'd2,
        KIND_ALT1 = 2'd3
    } bit_kind_e;

    typedef struct packed {
        tick_t period;
        tick_t trans;
        tick_t smin;
        tick_t smax;
    } timing_t;

    localparam tick_t LCG_MUL = 32'd52253;
    localparam tick_t LCG_ADD = 32'd42767;
    localparam tick_t LCG_MOD = 32'd65213;

    // Nominal timing for one bit kind, in ticks.
    function automatic timing_t nominal_timing(bit_kind_e kind, int cpu);
        timing_t t;
        t.smin = tick_t'(cpu / 2);
        case (kind)
            KIND_ZERO: begin
                t.period = tick_t'(200 * cpu);
                t.trans  = tick_t'(100 * cpu);
                t.smax   = tick_t'(5 * cpu);
            end
            KIND_ONE: begin
                t.period = tick_t'(112 * cpu);
                t.trans  = tick_t'(56 * cpu);
                t.smax   = tick_t'(4 * cpu);
            end
            KIND_ALT0: begin
                t.period = tick_t'(208 * cpu);
                t.trans  = tick_t'(26 * cpu);
                t.smax   = tick_t'(2 * cpu);
            end
            default: begin
                t.period = tick_t'(208 * cpu);
                t.trans  = tick_t'(182 * cpu);
                t.smax   = tick_t'(2 * cpu);
            end
        endcase
        return t;
    endfunction

    // One generator step: wrap at 32 bits, then reduce.
    function automatic tick_t lcg_next(tick_t s);
        tick_t prod;
        prod = s * LCG_MUL + LCG_ADD;
        return prod % LCG_MOD;
    endfunction

endpackage

// File: rtl/dcc_jit_lcg.sv
module dcc_jit_lcg
    import dcc_jit_pkg::*;
#(
    parameter tick_t SEED_INIT = 32'hB7A11BAE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output tick_t draw
);
    tick_t seed_q;

    assign draw = lcg_next(seed_q);

    always_ff @(posedge clk) begin
        if (rst)       seed_q <= SEED_INIT;
        else if (step) seed_q <= draw;
    end

    // R7: after a step the seed is reduced below the modulus
    p_seed_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        step |=> (seed_q < LCG_MOD));

    // R9: without a draw the seed does not move
    p_seed_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(seed_q));
endmodule

// File: rtl/dcc_jit_sched.sv
module dcc_jit_sched
    import dcc_jit_pkg::*;
#(
    parameter int REPEAT_LIMIT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  bit_kind_e kind,
    output logic      reload
);
    localparam int RW = $clog2(REPEAT_LIMIT + 1);
    localparam logic [RW-1:0] LIMIT = RW'(REPEAT_LIMIT);

    logic          have_q;
    bit_kind_e     last_q;
    logic [RW-1:0] rep_q;

    assign reload = accept && (!have_q || (kind != last_q) || (rep_q >= LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            last_q <= KIND_ONE;
            rep_q  <= '0;
        end else if (accept) begin
            if (reload) begin
                have_q <= 1'b1;
                last_q <= kind;
                rep_q  <= '0;
            end else begin
                rep_q  <= rep_q + 1'b1;
            end
        end
    end

    // R8: the reuse counter never passes the limit
    p_rep_limit_r8: assert property (@(posedge clk) disable iff (rst)
        rep_q <= LIMIT);

    // R8: a reused timing advances the reuse count by one
    p_rep_step_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && !reload) |=> (rep_q == RW'($past(rep_q) + 1'b1)));
endmodule

// File: rtl/dcc_jit_phase.sv
module dcc_jit_phase #(
    parameter int TW       = 12,
    parameter int DEADBAND = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] period,
    input  logic [TW-1:0] trans,
    output logic          ready,
    output logic          out_a,
    output logic          out_b
);
    localparam logic [TW-1:0] DB = TW'(DEADBAND);

    logic          started_q;
    logic [TW-1:0] cnt_q;

    assign ready = !started_q || (cnt_q == period - 1'b1);
    assign out_a = started_q && (cnt_q >= DB) && (cnt_q < trans);
    assign out_b = started_q && (cnt_q >= trans + DB) && (cnt_q < period);

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            cnt_q     <= '0;
        end else if (ready) begin
            started_q <= 1'b1;
            cnt_q     <= '0;
        end else begin
            cnt_q     <= cnt_q + 1'b1;
        end
    end

    // R3: the two bridge halves never conduct together
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        !(out_a && out_b));

    generate
        if (DEADBAND > 0) begin : g_gap
            // R3: a falling edge on one side leaves a gap before the other
            p_gap_after_a_r3: assert property (@(posedge clk) disable iff (rst)
                $fell(out_a) |-> !out_b);
            p_gap_after_b_r3: assert property (@(posedge clk) disable iff (rst)
                $fell(out_b) |-> !out_a);
        end
    endgenerate

    // R4: a handshake restarts the symbol on the next tick
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        ready |=> (started_q && cnt_q == '0));
endmodule

// File: rtl/dcc_jitter_gen.sv
module dcc_jitter_gen
    import dcc_jit_pkg::*;
#(
    parameter int CLK_PER_US   = 4,
    parameter int DEADBAND     = 1,
    parameter int REPEAT_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       jitter_en,
    input  logic       in_valid,
    input  logic [1:0] in_code,
    output logic       in_ready,
    output logic       out_a,
    output logic       out_b
);
    localparam int    MAX_TICKS  = 220 * CLK_PER_US;
    localparam int    TW         = $clog2(MAX_TICKS);
    localparam tick_t SPREAD_CAP = tick_t'(5 * CLK_PER_US);

    logic      accept;
    logic      reload;
    bit_kind_e kind_in;
    timing_t   nom;
    tick_t     range_w;
    tick_t     draw;
    tick_t     spread_new;

    tick_t     period_q;
    tick_t     trans_q;
    tick_t     spread_q;
    bit_kind_e kind_q;

    assign accept   = in_ready;
    assign kind_in  = in_valid ? bit_kind_e'(in_code) : KIND_ONE;
    assign nom      = nominal_timing(kind_in, CLK_PER_US);
    assign range_w  = nom.smax - nom.smin;
    assign spread_new = jitter_en ? (draw % range_w) + nom.smin : '0;

    dcc_jit_lcg u_lcg (
        .clk  (clk),
        .rst  (rst),
        .step (reload && jitter_en),
        .draw (draw)
    );

    dcc_jit_sched #(
        .REPEAT_LIMIT (REPEAT_LIMIT)
    ) u_sched (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .kind   (kind_in),
        .reload (reload)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= tick_t'(112 * CLK_PER_US);
            trans_q  <= tick_t'(56 * CLK_PER_US);
            spread_q <= '0;
            kind_q   <= KIND_ONE;
        end else if (reload) begin
            period_q <= nom.period + (spread_new << 1);
            trans_q  <= nom.trans + spread_new;
            spread_q <= spread_new;
            kind_q   <= kind_in;
        end
    end

    dcc_jit_phase #(
        .TW       (TW),
        .DEADBAND (DEADBAND)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .period (TW'(period_q)),
        .trans  (TW'(trans_q)),
        .ready  (in_ready),
        .out_a  (out_a),
        .out_b  (out_b)
    );

    // R5: DCC symbols keep both halves equal
    p_symmetric_r5: assert property (@(posedge clk) disable iff (rst)
        (kind_q == KIND_ZERO || kind_q == KIND_ONE) |-> (period_q == (trans_q << 1)));

    // R6: the held spread never exceeds the widest allowance
    p_spread_cap_r6: assert property (@(posedge clk) disable iff (rst)
        spread_q < SPREAD_CAP);

    // R9: a reload with jitter off installs nominal timing
    p_jitter_off_r9: assert property (@(posedge clk) disable iff (rst)
        (reload && !jitter_en) |=> (spread_q == '0));
endmodule

// File: tb/dcc_jitter_gen_bench.sv
module dcc_jitter_gen_bench;
    localparam int CPU = 4;
    localparam int DB  = 1;
    localparam int NB  = 130;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       jitter_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_code = 2'd0;
    logic       in_ready, out_a, out_b;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    dcc_jitter_gen #(.CLK_PER_US(CPU), .DEADBAND(DB), .REPEAT_LIMIT(4)) u_dcc_jitter_gen (
        .clk(clk), .rst(rst), .jitter_en(jitter_en), .in_valid(in_valid),
        .in_code(in_code), .in_ready(in_ready), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nom_p(input int k);
        return (k == 0) ? 200 * CPU : (k == 1) ? 112 * CPU : 208 * CPU;
    endfunction
    function automatic int nom_t(input int k);
        return (k == 0) ? 100 * CPU : (k == 1) ? 56 * CPU : (k == 2) ? 26 * CPU : 182 * CPU;
    endfunction
    function automatic int s_max(input int k);
        return (k == 0) ? 5 * CPU : (k == 1) ? 4 * CPU : 2 * CPU;
    endfunction

    // reference generator state
    int unsigned m_seed = 32'hB7A11BAE;
    int  m_last = 0;
    bit  m_have = 0;
    int  m_rep = 0;
    int  m_sp = 0;

    task automatic drive_stim(input int n);
        if (n < 8) begin
            jitter_en = 0; in_valid = 1; in_code = 2'(n % 4);
        end else if (n < 11) begin
            jitter_en = 0; in_valid = 0; in_code = 2'd0;
        end else if (n < 25) begin
            jitter_en = 1; in_valid = 1; in_code = 2'd1;
        end else if (n < 37) begin
            jitter_en = 1; in_valid = 1; in_code = 2'd0;
        end else if (n < 41) begin
            jitter_en = 0; in_valid = 1; in_code = 2'd0;
        end else begin
            in_code   = 2'($urandom % 4);
            in_valid  = ($urandom % 10) != 0;
            jitter_en = ($urandom % 8) != 0;
        end
    endtask

    initial begin
        int ha, hb, tot, n;
        int cur_k, cur_p, cur_t, prev_s, s_meas;
        bit have_bit, cur_reload, cur_en, cur_idle;
        string tg;
        void'($urandom(1234));
        ha = 0; hb = 0; tot = 0; n = 0; prev_s = 0;
        cur_k = 1; cur_p = 0; cur_t = 0;
        have_bit = 0; cur_reload = 0; cur_en = 0; cur_idle = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_a == 0 && out_b == 0, "R1 outputs low in reset", {out_a, out_b}, 0);
        drive_stim(0);
        @(posedge clk); #1 rst = 0;
        while (n < NB) begin
            @(negedge clk);
            if (have_bit) begin
                tot++; ha += int'(out_a); hb += int'(out_b);
            end
            if (in_ready) begin
                if (have_bit) begin
                    s_meas = ha + DB - nom_t(cur_k);
                    tg = cur_idle ? "R4 idle one-bit period" : (cur_k >= 2 ? "R10 alt period" : "R2 period");
                    chk(tot == cur_p, tg, tot, cur_p);
                    chk(ha == cur_t - DB, "R7 out_a high time (spread sequence)", ha, cur_t - DB);
                    chk(hb == cur_p - cur_t - DB, cur_k >= 2 ? "R10 out_b high time" : "R2 out_b high time",
                        hb, cur_p - cur_t - DB);
                    if (cur_k < 2) chk(ha == hb, "R5 equal halves", ha, hb);
                    chk(tot - ha - hb == 2 * DB, "R3 guard ticks", tot - ha - hb, 2 * DB);
                    if (cur_reload && cur_en)
                        chk(s_meas >= CPU / 2 && s_meas <= s_max(cur_k) - 1, "R6 spread range",
                            s_meas, CPU / 2);
                    if (cur_reload && !cur_en) chk(s_meas == 0, "R9 no spread when disabled", s_meas, 0);
                    if (!cur_reload) chk(s_meas == prev_s, "R8 spread reused", s_meas, prev_s);
                    prev_s = s_meas;
                end else begin
                    chk(out_a == 0 && out_b == 0, "R1 outputs low after reset", {out_a, out_b}, 0);
                    chk(in_ready == 1, "R1 ready after reset", in_ready, 1);
                end
                // reference model of the accepted code
                cur_idle = !in_valid;
                cur_k = in_valid ? int'(in_code) : 1;
                cur_en = jitter_en;
                cur_reload = !m_have || cur_k != m_last || m_rep >= 4;
                if (cur_reload) begin
                    if (cur_en) begin
                        m_seed = (m_seed * 32'd52253 + 32'd42767) % 32'd65213;
                        m_sp = int'(m_seed % 32'(s_max(cur_k) - CPU / 2)) + CPU / 2;
                    end else begin
                        m_sp = 0;
                    end
                    m_last = cur_k; m_have = 1; m_rep = 0;
                end else begin
                    m_rep++;
                end
                cur_p = nom_p(cur_k) + 2 * m_sp;
                cur_t = nom_t(cur_k) + m_sp;
                ha = 0; hb = 0; tot = 0;
                have_bit = 1;
                n++;
                @(posedge clk); #1;
                drive_stim(n);
            end else if (have_bit && tot > 1) begin
                if (tot == 2) chk(in_ready == 0, "R4 ready low inside symbol", in_ready, 0);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule